// File: doc/BRIEF.md
# Binary-Weight Convolution Processing Element

This block is the arithmetic core of a binarized convolution accelerator. On every accepted beat it takes one packed word of 32 single-bit kernel weights and 32 two-bit unsigned activations. For each lane, the weight bit selects whether the activation is added or subtracted. The 32 signed lane terms are reduced by an adder tree, and the beat total is merged into a signed 32-bit running accumulator.

A controller frames one dot product as a sequence of beats. It marks the first beat with the clear control, which restarts the accumulation, and the final beat with the last flag. The accumulated value, including the last beat, appears on the result port with a one-cycle valid pulse two cycles after that beat was presented. The accumulator arithmetic is two's complement and wraps on overflow.

Top module: `binconv_pe`

## Requirements
- R1: Weight bit i pairs with activation bits [2i+1:2i]. Weight value 1 adds the activation and weight value 0 subtracts it. Activations are unsigned integers from 0 to 3.
- R2: A single beat contributes between -96 and +96. An all-ones weight word with every activation at 3 gives +96. An all-zeros weight word with every activation at 3 gives -96.
- R3: A valid beat with clear asserted replaces the accumulator with that beat's sum and discards the previous value.
- R4: A valid beat without clear adds its sum to the current accumulator value, using signed 32-bit wraparound.
- R5: Cycles without input valid leave the accumulator, and therefore the result port, unchanged.
- R6: A valid beat with the last flag, presented in cycle t, produces a one-cycle result-valid pulse in cycle t+2. In that cycle the result includes that beat. Result-valid is never asserted without such a beat.
- R7: The result port always shows the accumulator value, including the effect of every accepted beat up to two cycles earlier.
- R8: Synchronous active-high reset clears the accumulator and all valid flags. A beat after reset that has no clear accumulates onto zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| beat_valid_i | input | 1 | Input beat qualifier |
| beat_clear_i | input | 1 | Restart the accumulation with this beat |
| beat_last_i | input | 1 | Final beat of a dot product |
| wgt_word_i | input | 32 | Packed weight bits, one per lane |
| act_vec_i | input | 64 | Activations, 2 bits per lane, lane i at [2i+1:2i] |
| res_valid_o | output | 1 | Result pulse |
| res_sum_o | output | 32 | Signed accumulator value |

## Verification
The hardest case to reach is the point where a polarity or lane-pairing error hides inside a full-width sum. With random operands, a swapped or inverted lane can cancel out and go unseen. The stimulus therefore sweeps every lane on its own, across every activation value and both weight polarities, with all other activations at zero. It then drives the saturating all-ones and all-zeros weight words with maximum activations, and finally runs random multi-beat frames with idle gaps, clears in the middle of a frame, and a reset while beats are still in the pipeline.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

    localparam int unsigned PE_LANES = 32;
    localparam int unsigned PE_ACT_W = 2;
    localparam int unsigned PE_ACC_W = 32;
    localparam int unsigned PE_SUM_W = PE_ACT_W + $clog2(PE_LANES) + 1;

    typedef logic signed [PE_SUM_W-1:0] beat_sum_t;
    typedef logic signed [PE_ACC_W-1:0] acc_t;

    typedef struct packed {
        logic      valid;
        logic      clear;
        logic      last;
        beat_sum_t sum;
    } stage1_t;

    function automatic acc_t widen(input beat_sum_t s);
        return {{(PE_ACC_W-PE_SUM_W){s[PE_SUM_W-1]}}, s};
    endfunction

endpackage

// File: rtl/bpe_lane_terms.sv
module bpe_lane_terms #(
    parameter int unsigned LANES = 32,
    parameter int unsigned ACT_W = 2,
    parameter int unsigned SUM_W = 8
) (
    input  logic [LANES-1:0]       wgt_i,
    input  logic [LANES*ACT_W-1:0] act_i,
    output logic [LANES*SUM_W-1:0] term_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SUM_W-1:0] mag;
        assign mag = {{(SUM_W-ACT_W){1'b0}}, act_i[i*ACT_W +: ACT_W]};
        assign term_o[i*SUM_W +: SUM_W] = wgt_i[i] ? mag : (~mag + 1'b1);
    end
endmodule

// File: rtl/bpe_adder_tree.sv
module bpe_adder_tree #(
    parameter int unsigned LEAVES = 32,
    parameter int unsigned W      = 8
) (
    input  logic [LEAVES*W-1:0] leaf_i,
    output logic [W-1:0]        root_o
);
    localparam int unsigned NODES = 2*LEAVES - 1;

    logic [W-1:0] node [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        assign node[LEAVES-1+i] = leaf_i[i*W +: W];
    end

    for (genvar k = 0; k < LEAVES-1; k++) begin : g_inner
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    assign root_o = node[0];
endmodule

// File: rtl/bpe_accum.sv
module bpe_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             upd_i,
    input  logic             load_i,
    input  logic             fire_i,
    input  logic [ACC_W-1:0] addend_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             fire_o
);
    logic [ACC_W-1:0] acc_q;
    logic             fire_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= upd_i & fire_i;
            if (upd_i) begin
                acc_q <= load_i ? addend_i : (acc_q + addend_i);
            end
        end
    end

    assign acc_o  = acc_q;
    assign fire_o = fire_q;
endmodule

// File: rtl/binconv_pe.sv
module binconv_pe
    import bpe_pkg::*;
(
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         beat_valid_i,
    input  logic                         beat_clear_i,
    input  logic                         beat_last_i,
    input  logic [PE_LANES-1:0]          wgt_word_i,
    input  logic [PE_LANES*PE_ACT_W-1:0] act_vec_i,
    output logic                         res_valid_o,
    output logic [PE_ACC_W-1:0]          res_sum_o
);
    logic [PE_LANES*PE_SUM_W-1:0] terms;
    logic [PE_SUM_W-1:0]          tree_sum;
    stage1_t                      s1_q;
    acc_t                         addend;

    bpe_lane_terms #(
        .LANES (PE_LANES),
        .ACT_W (PE_ACT_W),
        .SUM_W (PE_SUM_W)
    ) lanes_i (
        .wgt_i  (wgt_word_i),
        .act_i  (act_vec_i),
        .term_o (terms)
    );

    bpe_adder_tree #(
        .LEAVES (PE_LANES),
        .W      (PE_SUM_W)
    ) tree_i (
        .leaf_i (terms),
        .root_o (tree_sum)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= beat_valid_i;
            s1_q.clear <= beat_clear_i;
            s1_q.last  <= beat_last_i;
            s1_q.sum   <= beat_sum_t'(tree_sum);
        end
    end

    assign addend = widen(s1_q.sum);

    bpe_accum #(
        .ACC_W (PE_ACC_W)
    ) acc_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .upd_i    (s1_q.valid),
        .load_i   (s1_q.clear),
        .fire_i   (s1_q.last),
        .addend_i (addend),
        .acc_o    (res_sum_o),
        .fire_o   (res_valid_o)
    );
endmodule

// File: rtl/bpe_checker.sv
module bpe_checker #(
    parameter int unsigned LANES = 32,
    parameter int unsigned ACC_W = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             beat_valid_i,
    input logic             beat_clear_i,
    input logic             beat_last_i,
    input logic             res_valid_o,
    input logic [ACC_W-1:0] res_sum_o
);
    localparam int BEAT_MAX = 3 * LANES;

    assert_last_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (beat_valid_i && beat_last_i) |-> ##2 res_valid_o);

    assert_pulse_cause_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        res_valid_o |-> $past(beat_valid_i && beat_last_i, 2));

    assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!beat_valid_i && !$past(beat_valid_i)) |=> $stable(res_sum_o));

    assert_clear_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (beat_valid_i && beat_clear_i) |-> ##2
        (($signed(res_sum_o) <= BEAT_MAX) && ($signed(res_sum_o) >= -BEAT_MAX)));

    assert_reset_clear_R8: assert property (@(posedge clk_i)
        rst_i |=> (!res_valid_o && res_sum_o == '0));
endmodule

bind binconv_pe bpe_checker #(
    .LANES (bpe_pkg::PE_LANES),
    .ACC_W (bpe_pkg::PE_ACC_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .beat_valid_i (beat_valid_i),
    .beat_clear_i (beat_clear_i),
    .beat_last_i  (beat_last_i),
    .res_valid_o  (res_valid_o),
    .res_sum_o    (res_sum_o)
);

// File: tb/binconv_pe_tb_top.sv
`timescale 1ns/1ps
module binconv_pe_tb_top;
    localparam int LANES = 32;
    localparam int ACT_W = 2;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   bv = 1'b0, bc = 1'b0, bl = 1'b0;
    logic [LANES-1:0]       wgt = '0;
    logic [LANES*ACT_W-1:0] act = '0;
    logic                   rv;
    logic [31:0]            rs;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string phase  = "R8";

    logic signed [31:0] exp_acc = 0;
    logic               d1v = 0, d2v = 0;
    logic signed [31:0] d1s = 0, d2s = 0;

    always #2.5 clk = ~clk;

    binconv_pe dut_i (
        .clk_i(clk), .rst_i(rst), .beat_valid_i(bv), .beat_clear_i(bc),
        .beat_last_i(bl), .wgt_word_i(wgt), .act_vec_i(act),
        .res_valid_o(rv), .res_sum_o(rs)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act_v, input longint exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    function automatic int beat_sum(input logic [LANES-1:0] w,
                                    input logic [LANES*ACT_W-1:0] a);
        int s = 0;
        for (int i = 0; i < LANES; i++) begin
            int v = int'(a[i*ACT_W +: ACT_W]);
            s += w[i] ? v : -v;
        end
        return s;
    endfunction

    // Reference model: result in cycle t reflects beats up to cycle t-2 (R7)
    always @(negedge clk) begin
        if (rst) begin
            exp_acc = 0; d1v = 0; d1s = 0; d2v = 0; d2s = 0;
        end else begin
            chk(rv == d2v, "R6", "result valid", rv, d2v);
            chk($signed(rs) == d2s, phase, "result sum (R7)", $signed(rs), d2s);
            if (bv) begin
                if (bc) exp_acc = beat_sum(wgt, act);
                else    exp_acc = exp_acc + beat_sum(wgt, act);
            end
            d2v = d1v; d2s = d1s;
            d1v = bv && bl; d1s = exp_acc;
        end
    end

    task automatic beat(input logic [LANES-1:0] w, input logic [LANES*ACT_W-1:0] a,
                        input bit c, input bit l);
        @(posedge clk); #1;
        bv = 1'b1; bc = c; bl = l; wgt = w; act = a;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            bv = 1'b0; bc = 1'b0; bl = 1'b0;
            wgt = $urandom; act = {$urandom, $urandom};
        end
    endtask

    task automatic expect_pulse(input int exp_v, input string req);
        bit seen = 0;
        for (int k = 0; k < 5 && !seen; k++) begin
            @(negedge clk);
            if (rv) begin
                seen = 1;
                chk($signed(rs) == exp_v, req, "directed result", $signed(rs), exp_v);
            end
        end
        chk(seen, req, "directed pulse seen", seen, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        chk(0, "WD", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [LANES*ACT_W-1:0] maxact;
        maxact = '1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(rv == 1'b0, "R8", "valid after reset", rv, 0);
        chk(rs == 32'd0, "R8", "sum after reset", rs, 0);

        // R8: first beat without clear accumulates onto zero
        phase = "R8";
        beat('1, {LANES{2'd1}}, 1'b0, 1'b1);
        idle(1);
        expect_pulse(LANES, "R8");

        // R1: every lane alone, every activation value, both polarities
        phase = "R1";
        for (int ln = 0; ln < LANES; ln++)
            for (int av = 0; av < 4; av++)
                for (int wb = 0; wb < 2; wb++) begin
                    logic [LANES*ACT_W-1:0] a;
                    logic [LANES-1:0] w;
                    a = '0; a[ln*ACT_W +: ACT_W] = av[1:0];
                    w = $urandom; w[ln] = wb[0];
                    beat(w, a, 1'b1, 1'b1);
                end
        idle(3);

        // R2: extremes
        phase = "R2";
        beat('1, maxact, 1'b1, 1'b1);
        idle(1);
        expect_pulse(96, "R2");
        beat('0, maxact, 1'b1, 1'b1);
        idle(1);
        expect_pulse(-96, "R2");

        // R4: accumulation of extremes over several beats
        phase = "R4";
        beat('0, maxact, 1'b1, 1'b0);
        beat('0, maxact, 1'b0, 1'b0);
        beat('0, maxact, 1'b0, 1'b1);
        idle(1);
        expect_pulse(-288, "R4");

        // R3: clear mid-frame discards earlier beats
        phase = "R3";
        beat('1, maxact, 1'b1, 1'b0);
        beat('1, maxact, 1'b0, 1'b0);
        beat('0, {LANES{2'd2}}, 1'b1, 1'b1);
        idle(1);
        expect_pulse(-64, "R3");

        // R5: idle gaps inside a frame
        phase = "R5";
        beat('1, maxact, 1'b1, 1'b0);
        idle(4);
        beat('1, {LANES{2'd1}}, 1'b0, 1'b1);
        idle(1);
        expect_pulse(128, "R5");

        // R4/R5: random frames with random lengths and gaps
        phase = "R4";
        for (int f = 0; f < 60; f++) begin
            int n = $urandom_range(1, 8);
            for (int b = 0; b < n; b++) begin
                logic [LANES*ACT_W-1:0] a;
                a = ($urandom_range(0, 3) == 0) ? maxact : {$urandom, $urandom};
                beat($urandom, a, b == 0, b == n - 1);
                if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 2));
            end
        end
        idle(3);

        // R8: reset with beats in flight
        phase = "R8";
        beat('1, maxact, 1'b1, 1'b0);
        beat('1, maxact, 1'b0, 1'b1);
        @(posedge clk); #1 bv = 1'b0; rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(rs == 32'd0 && rv == 1'b0, "R8", "reset mid-frame", rs, 0);
        beat('0, {LANES{2'd1}}, 1'b0, 1'b1);
        idle(1);
        expect_pulse(-32, "R8");
        idle(3);
        finish_run();
    end
endmodule